// File: doc/BRIEF.md
# Dispatch Group Former

This block sits between instruction decode and the issue queues. It takes decoded instructions one at a time, each carrying a 3-bit class code and an opaque payload, and packs them into dispatch groups. A group has `NB_SLOTS` non-branch slots (four by default) and `BR_SLOTS` branch slots (two by default), so a default group carries up to six instructions. The block keeps program order. If an instruction cannot legally join the group being built, that group is closed and the instruction starts the next one.

Classes control placement. A class can be pinned to the first slot. A class can be cracked into a pair or a quad of non-branch slots. A permute class is limited to the two lowest slots. Branches take the branch slots and do not close a group by themselves, but the last branch slot, once filled, closes the group. A finished group is presented with one valid bit per slot under a valid/ready handshake. While the consumer holds it off, the group stays unchanged and no new instruction is taken.

Top module: `dgf_group_former`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Bit i of `out_slot_vld` marks slot i, whose payload is `out_slot_pay[i*PAY_W +: PAY_W]`. Non-branch instructions (class codes 0, 1, 2, 3, 5) fill slots 0 to 3 lowest first in arrival order. A group never holds more than four non-branch slots.
- R3: A branch (class 4) takes slot 4 for the first branch and slot 5 for the second. A first branch leaves the group open. The second branch closes the group with itself as its last member.
- R4: A pinned instruction (class 1) is placed only in slot 0. If slot 0 is already used, the open group closes and the pinned instruction starts the next group.
- R5: A pair instruction (class 2) needs an empty non-branch half. It occupies slots 0 and 1, and its payload is copied into both.
- R6: A quad instruction (class 3) needs an empty non-branch half. It occupies slots 0 to 3 with its payload copied into each. Branches may still join that group afterwards.
- R7: A permute instruction (class 5) may go only in slot 0 or 1. If both are used, the group closes and the permute starts the next group.
- R8: An instruction that does not fit closes the open group and begins the next group. Instructions leave in exactly the order they were accepted, and none is lost or duplicated.
- R9: In a cycle with `in_ready` high and `in_valid` low, an open non-empty group closes.
- R10: While `out_valid` is high and `out_ready` is low, the output group stays stable and `in_ready` is low.
- R11: Class codes 6 and 7 are placed like a simple instruction (class 0).
- R12: A group closed by a clock edge is visible at the output in the cycle right after that edge. The output never presents an empty group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction is taken at this edge |
| in_cls | input | 3 | Class code of the offered instruction |
| in_pay | input | PAY_W | Payload of the offered instruction |
| out_valid | output | 1 | A finished group is presented |
| out_ready | input | 1 | The consumer takes the group |
| out_slot_vld | output | NB_SLOTS+BR_SLOTS | Per-slot occupancy of the presented group |
| out_slot_pay | output | (NB_SLOTS+BR_SLOTS)*PAY_W | Per-slot payloads of the presented group |

## Verification
A wrong slot-occupancy count inside the block shows up at the ports one group later. The next group closes too early or too late, or it places an instruction in the wrong slot. A scoreboard that rebuilds every expected group from the accepted stream catches this on the first group it pops. A lost or repeated instruction shows up as a payload mismatch or as a group left in the queue at the end. A stall fault shows as an output group that changes, or an instruction taken, while `out_ready` is low, and it is seen in the same stalled cycle.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

   // class codes carried on in_cls
   localparam logic [2:0] CLS_PLAIN  = 3'd0;
   localparam logic [2:0] CLS_HEAD   = 3'd1;
   localparam logic [2:0] CLS_PAIR   = 3'd2;
   localparam logic [2:0] CLS_QUAD   = 3'd3;
   localparam logic [2:0] CLS_BRANCH = 3'd4;
   localparam logic [2:0] CLS_PERM   = 3'd5;

   localparam int PAIR_SPAN = 2;

endpackage

// File: rtl/dgf_fit.sv
// Decides whether one instruction fits into a group with the given
// occupancy, and which slots it would take.
module dgf_fit
   import dgf_pkg::*;
#(
   parameter int NB_SLOTS   = 4,
   parameter int BR_SLOTS   = 2,
   parameter int PERM_SLOTS = 2,
   localparam int TOT = NB_SLOTS + BR_SLOTS,
   localparam int NBW = $clog2(NB_SLOTS + 1),
   localparam int BRW = $clog2(BR_SLOTS + 1)
) (
   input  logic [NBW-1:0] nb_used,
   input  logic [BRW-1:0] br_used,
   input  logic [2:0]     cls,
   output logic           fits,
   output logic           closes,
   output logic [TOT-1:0] mask,
   output logic [NBW-1:0] nb_next,
   output logic [BRW-1:0] br_next
);

   logic           is_br;
   logic [NBW-1:0] span;

   always_comb begin
      is_br = (cls == CLS_BRANCH);
      case (cls)
         CLS_PAIR: span = NBW'(PAIR_SPAN);
         CLS_QUAD: span = NBW'(NB_SLOTS);
         default:  span = NBW'(1);
      endcase
      case (cls)
         CLS_HEAD, CLS_PAIR, CLS_QUAD: fits = (nb_used == '0);
         CLS_BRANCH:                   fits = (br_used < BRW'(BR_SLOTS));
         CLS_PERM:                     fits = (nb_used < NBW'(PERM_SLOTS));
         default:                      fits = (nb_used < NBW'(NB_SLOTS));
      endcase
      closes  = is_br && (int'(br_used) + 1 == BR_SLOTS);
      nb_next = is_br ? nb_used : nb_used + span;
      br_next = is_br ? br_used + BRW'(1) : br_used;
   end

   for (genvar i = 0; i < NB_SLOTS; i++) begin : g_nb_mask
      assign mask[i] = !is_br && (int'(nb_used) <= i)
                       && (i < int'(nb_used) + int'(span));
   end

   for (genvar j = 0; j < BR_SLOTS; j++) begin : g_br_mask
      assign mask[NB_SLOTS+j] = is_br && (int'(br_used) == j);
   end

endmodule

// File: rtl/dgf_merge.sv
// Writes one instruction's payload into the slots selected by a mask.
module dgf_merge #(
   parameter int TOT   = 6,
   parameter int PAY_W = 16
) (
   input  logic [TOT-1:0]       base_vld,
   input  logic [TOT*PAY_W-1:0] base_pay,
   input  logic [TOT-1:0]       mask,
   input  logic [PAY_W-1:0]     pay,
   output logic [TOT-1:0]       vld_o,
   output logic [TOT*PAY_W-1:0] pay_o
);

   for (genvar i = 0; i < TOT; i++) begin : g_slot
      assign vld_o[i] = base_vld[i] | mask[i];
      assign pay_o[i*PAY_W +: PAY_W] = mask[i] ? pay : base_pay[i*PAY_W +: PAY_W];
   end

endmodule

// File: rtl/dgf_group_former.sv
module dgf_group_former
   import dgf_pkg::*;
#(
   parameter int PAY_W      = 16,
   parameter int NB_SLOTS   = 4,
   parameter int BR_SLOTS   = 2,
   parameter int PERM_SLOTS = 2,
   localparam int TOT = NB_SLOTS + BR_SLOTS,
   localparam int NBW = $clog2(NB_SLOTS + 1),
   localparam int BRW = $clog2(BR_SLOTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [2:0]           in_cls,
   input  logic [PAY_W-1:0]     in_pay,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [TOT-1:0]       out_slot_vld,
   output logic [TOT*PAY_W-1:0] out_slot_pay
);

   // elaboration-time parameter checks
   if (NB_SLOTS < PAIR_SPAN) begin : g_bad_nb
      $error("NB_SLOTS must be at least the pair span");
   end
   if (BR_SLOTS < 2) begin : g_bad_br
      $error("BR_SLOTS must be at least 2");
   end
   if (PERM_SLOTS < 1 || PERM_SLOTS > NB_SLOTS) begin : g_bad_perm
      $error("PERM_SLOTS must lie in 1..NB_SLOTS");
   end
   if (PAY_W < 1) begin : g_bad_pay
      $error("PAY_W must be positive");
   end

   // group being assembled
   logic [TOT-1:0]       acc_vld;
   logic [TOT*PAY_W-1:0] acc_pay;
   logic [NBW-1:0]       acc_nb;
   logic [BRW-1:0]       acc_br;

   // presented group
   logic                 out_v;
   logic [TOT-1:0]       out_vld_q;
   logic [TOT*PAY_W-1:0] out_pay_q;

   logic out_free, take, acc_open;

   logic                 a_fits, a_close;
   logic [TOT-1:0]       a_mask;
   logic [NBW-1:0]       a_nb_next;
   logic [BRW-1:0]       a_br_next;
   logic                 f_fits, f_close;
   logic [TOT-1:0]       f_mask;
   logic [NBW-1:0]       f_nb_next;
   logic [BRW-1:0]       f_br_next;

   logic [TOT-1:0]       a_vld;
   logic [TOT*PAY_W-1:0] a_pay;
   logic [TOT-1:0]       f_vld;
   logic [TOT*PAY_W-1:0] f_pay;

   assign out_free = !out_v || out_ready;
   assign take     = in_valid && out_free;
   assign acc_open = |acc_vld;

   // placement into the open group
   dgf_fit #(.NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS), .PERM_SLOTS(PERM_SLOTS)) fit_open_i (
      .nb_used (acc_nb),
      .br_used (acc_br),
      .cls     (in_cls),
      .fits    (a_fits),
      .closes  (a_close),
      .mask    (a_mask),
      .nb_next (a_nb_next),
      .br_next (a_br_next)
   );

   // placement into a fresh group
   dgf_fit #(.NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS), .PERM_SLOTS(PERM_SLOTS)) fit_fresh_i (
      .nb_used ('0),
      .br_used ('0),
      .cls     (in_cls),
      .fits    (f_fits),
      .closes  (f_close),
      .mask    (f_mask),
      .nb_next (f_nb_next),
      .br_next (f_br_next)
   );

   dgf_merge #(.TOT(TOT), .PAY_W(PAY_W)) merge_open_i (
      .base_vld (acc_vld),
      .base_pay (acc_pay),
      .mask     (a_mask),
      .pay      (in_pay),
      .vld_o    (a_vld),
      .pay_o    (a_pay)
   );

   dgf_merge #(.TOT(TOT), .PAY_W(PAY_W)) merge_fresh_i (
      .base_vld ('0),
      .base_pay ('0),
      .mask     (f_mask),
      .pay      (in_pay),
      .vld_o    (f_vld),
      .pay_o    (f_pay)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_vld   <= '0;
         acc_pay   <= '0;
         acc_nb    <= '0;
         acc_br    <= '0;
         out_v     <= 1'b0;
         out_vld_q <= '0;
         out_pay_q <= '0;
      end else if (out_free) begin
         if (take && a_fits && !a_close) begin
            acc_vld <= a_vld;
            acc_pay <= a_pay;
            acc_nb  <= a_nb_next;
            acc_br  <= a_br_next;
            out_v   <= 1'b0;
         end else if (take && a_fits) begin
            out_vld_q <= a_vld;
            out_pay_q <= a_pay;
            out_v     <= 1'b1;
            acc_vld   <= '0;
            acc_nb    <= '0;
            acc_br    <= '0;
         end else if (take) begin
            out_vld_q <= acc_vld;
            out_pay_q <= acc_pay;
            out_v     <= 1'b1;
            acc_vld   <= f_vld;
            acc_pay   <= f_pay;
            acc_nb    <= f_nb_next;
            acc_br    <= f_br_next;
         end else if (!in_valid && acc_open) begin
            out_vld_q <= acc_vld;
            out_pay_q <= acc_pay;
            out_v     <= 1'b1;
            acc_vld   <= '0;
            acc_nb    <= '0;
            acc_br    <= '0;
         end else begin
            out_v <= 1'b0;
         end
      end
   end

   assign in_ready     = out_free;
   assign out_valid    = out_v;
   assign out_slot_vld = out_vld_q;
   assign out_slot_pay = out_pay_q;

   // ---------------- assertions ----------------

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_slot_vld) && $stable(out_slot_pay));

   // R10
   stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> $stable(acc_vld) && $stable(acc_nb) && $stable(acc_br));

   // R12
   no_empty_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (|out_slot_vld));

   // R3
   br_open_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_br < BRW'(BR_SLOTS));

   // R9
   idle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready && !in_valid && acc_open |=> out_valid);

   // R8
   fresh_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> f_fits && !f_close);

   for (genvar i = 0; i + 1 < NB_SLOTS; i++) begin : g_nb_chk
      // R2
      nb_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && out_slot_vld[i+1] |-> out_slot_vld[i]);
   end

   for (genvar j = 0; j + 1 < BR_SLOTS; j++) begin : g_br_chk
      // R3
      br_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && out_slot_vld[NB_SLOTS+j+1] |-> out_slot_vld[NB_SLOTS+j]);
   end

endmodule

// File: tb/dgf_group_former_tb.sv
`timescale 1ns/1ps
module dgf_group_former_tb_top;

   localparam int PW  = 16;
   localparam int NB  = 4;
   localparam int BR  = 2;
   localparam int TOT = NB + BR;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic                 rst_n;
   logic                 in_valid;
   logic                 in_ready;
   logic [2:0]           in_cls;
   logic [PW-1:0]        in_pay;
   logic                 out_valid;
   logic                 out_ready;
   logic [TOT-1:0]       out_slot_vld;
   logic [TOT*PW-1:0]    out_slot_pay;

   dgf_group_former #(.PAY_W(PW), .NB_SLOTS(NB), .BR_SLOTS(BR), .PERM_SLOTS(2)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_cls       (in_cls),
      .in_pay       (in_pay),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_slot_vld (out_slot_vld),
      .out_slot_pay (out_slot_pay)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // scoreboard
   logic [TOT-1:0]    q_v[$];
   logic [TOT*PW-1:0] q_p[$];
   string             q_tag[$];
   string             cur_tag = "R2";

   // reference group under construction
   int                m_nb = 0;
   int                m_br = 0;
   logic [TOT-1:0]    m_v  = '0;
   logic [TOT*PW-1:0] m_p  = '0;

   bit                mon_en = 1'b0;
   bit                prev_stall = 1'b0;
   logic [TOT-1:0]    prev_v;
   logic [TOT*PW-1:0] prev_p;

   task automatic chk(input bit ok, input string msg);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s", msg);
      end
   endtask

   function automatic logic [TOT*PW-1:0] masked(input logic [TOT-1:0] v, input logic [TOT*PW-1:0] p);
      logic [TOT*PW-1:0] r = '0;
      for (int i = 0; i < TOT; i++)
         if (v[i]) r[i*PW +: PW] = p[i*PW +: PW];
      return r;
   endfunction

   task automatic model_close();
      q_v.push_back(m_v);
      q_p.push_back(m_p);
      q_tag.push_back(cur_tag);
      m_v  = '0;
      m_p  = '0;
      m_nb = 0;
      m_br = 0;
   endtask

   task automatic model_add(input logic [2:0] c, input logic [PW-1:0] p);
      bit fit;
      int span;
      span = (c == 3'd2) ? 2 : (c == 3'd3) ? NB : 1;
      case (c)
         3'd1, 3'd2, 3'd3: fit = (m_nb == 0);
         3'd4:             fit = (m_br < BR);
         3'd5:             fit = (m_nb < 2);
         default:          fit = (m_nb < NB);
      endcase
      if (!fit) model_close();
      if (c == 3'd4) begin
         m_v[NB+m_br] = 1'b1;
         m_p[(NB+m_br)*PW +: PW] = p;
         m_br++;
         if (m_br == BR) model_close();
      end else begin
         for (int k = 0; k < span; k++) begin
            m_v[m_nb+k] = 1'b1;
            m_p[(m_nb+k)*PW +: PW] = p;
         end
         m_nb += span;
      end
   endtask

   // monitor: samples 3 ns after the falling edge, before the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (mon_en) begin
            if (prev_stall) begin
               chk(out_valid && out_slot_vld == prev_v && out_slot_pay == prev_p,
                   $sformatf("R10 stalled group changed: vld=%b/%b pay=%h exp vld=%b pay=%h",
                             out_valid, out_slot_vld, out_slot_pay, prev_v, prev_p));
            end
            if (out_valid && !out_ready) begin
               chk(in_ready == 1'b0,
                   $sformatf("R10 in_ready during stall: got %b exp 0", in_ready));
            end
            if (out_valid && out_ready) begin
               if (q_v.size() == 0) begin
                  chk(1'b0, $sformatf("R8 unexpected group: got vld=%b exp none", out_slot_vld));
               end else begin
                  logic [TOT-1:0]    ev;
                  logic [TOT*PW-1:0] ep;
                  string             et;
                  ev = q_v.pop_front();
                  ep = q_p.pop_front();
                  et = q_tag.pop_front();
                  chk(out_slot_vld == ev && masked(out_slot_vld, out_slot_pay) == masked(ev, ep),
                      $sformatf("%s group mismatch: got vld=%b pay=%h exp vld=%b pay=%h",
                                et, out_slot_vld, masked(out_slot_vld, out_slot_pay), ev, masked(ev, ep)));
               end
            end
            if (in_ready) begin
               if (in_valid) model_add(in_cls, in_pay);
               else if (m_v != '0) model_close();
            end
            prev_stall = out_valid && !out_ready;
            prev_v     = out_slot_vld;
            prev_p     = out_slot_pay;
         end
      end
   end

   task automatic send(input logic [2:0] c, input logic [PW-1:0] p);
      @(negedge clk);
      in_valid = 1'b1;
      in_cls   = c;
      in_pay   = p;
      #3;
      while (!in_ready) begin
         @(negedge clk);
         #3;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic run_tests();
      // R1: reset state
      #3;
      chk(out_valid == 1'b0, $sformatf("R1 out_valid after reset: got %b exp 0", out_valid));
      chk(in_ready == 1'b1, $sformatf("R1 in_ready after reset: got %b exp 1", in_ready));
      mon_en = 1'b1;

      // R2 + R9 + R12: four plain instructions then one idle cycle
      cur_tag = "R2";
      send(3'd0, 16'hA001); send(3'd0, 16'hA002);
      send(3'd0, 16'hA003); send(3'd0, 16'hA004);
      @(negedge clk); in_valid = 1'b0; #3;
      chk(out_valid == 1'b0, $sformatf("R9 group closed before idle: got %b exp 0", out_valid));
      @(negedge clk); #3;
      chk(out_valid == 1'b1, $sformatf("R12 group not shown after idle close: got %b exp 1", out_valid));
      chk(out_slot_vld == 6'b001111, $sformatf("R2 slot map: got %b exp 001111", out_slot_vld));
      idle(2);

      // R8: overflow of the non-branch half
      cur_tag = "R8";
      for (int i = 0; i < 5; i++) send(3'd0, 16'hB000 + 16'(i));
      idle(3);

      // R3: branches do not close, second branch is last
      cur_tag = "R3";
      send(3'd4, 16'hC001); send(3'd0, 16'hC002); send(3'd4, 16'hC003);
      @(negedge clk); in_valid = 1'b0; #3;
      chk(out_valid == 1'b1 && out_slot_vld == 6'b110001,
          $sformatf("R3 second branch close: got v=%b vld=%b exp v=1 vld=110001", out_valid, out_slot_vld));
      send(3'd4, 16'hC004);
      idle(3);

      // R4: pinned class
      cur_tag = "R4";
      send(3'd0, 16'hD001); send(3'd1, 16'hD002); send(3'd0, 16'hD003);
      idle(3);

      // R5: pair
      cur_tag = "R5";
      send(3'd2, 16'hD101); send(3'd0, 16'hD102); send(3'd0, 16'hD103); send(3'd0, 16'hD104);
      idle(3);

      // R6: quad, branch may still join
      cur_tag = "R6";
      send(3'd3, 16'hD201); send(3'd4, 16'hD202); send(3'd0, 16'hD203);
      idle(3);

      // R7: permute
      cur_tag = "R7";
      send(3'd0, 16'hD301); send(3'd5, 16'hD302);
      idle(3);
      send(3'd0, 16'hD303); send(3'd0, 16'hD304); send(3'd5, 16'hD305);
      idle(3);

      // R11: reserved codes
      cur_tag = "R11";
      send(3'd6, 16'hD401); send(3'd7, 16'hD402); send(3'd6, 16'hD403);
      send(3'd7, 16'hD404); send(3'd6, 16'hD405);
      idle(3);

      // R10: stall with a full group waiting
      cur_tag = "R10";
      @(negedge clk); out_ready = 1'b0;
      send(3'd0, 16'hE001); send(3'd4, 16'hE002); send(3'd4, 16'hE003);
      fork
         send(3'd0, 16'hE004);
         begin
            repeat (5) @(negedge clk);
            out_ready = 1'b1;
         end
      join
      idle(4);

      // R8: nothing left behind
      #3;
      chk(q_v.size() == 0 && m_v == '0,
          $sformatf("R8 groups left unseen: got %0d exp 0", q_v.size()));
   endtask

   initial begin
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_cls    = '0;
      in_pay    = '0;
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fork
         run_tests();
         begin
            repeat (20000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog expired: got running exp finished");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule